// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory whose bus never needs a dead cycle between a read and a write. Every rising clock edge may carry a new access: the edge samples chip enable, the read/write select, the word address and the byte write enables. The write data for an access arrives on the shared data bus in the same clock slot where a read issued at that edge would return its data. Each bus slot therefore belongs to exactly one access, and reads and writes can follow each other in any order at full rate.

Because write data trails its address, the array update is held in a pending register and committed on the following edge. A read that targets a word still in flight, whether captured but not committed or still arriving on the bus, is served by a per-byte bypass that merges the newest bytes over the array contents. A parameter chooses flow-through timing (one edge of latency, combinational read path) or pipelined timing (an extra output register, two edges of latency). Each byte lane stores one parity bit next to its eight data bits. The parity bits are written and read with their byte.

Top module: `zbt_sram`

## Requirements
- R1: An edge with `ce` low is a no-op. It writes nothing, and its data slot has `oe` low, even if `we` and the byte enables are high.
- R2: For a write sampled at edge n, `wdata` and `wpar` are taken at edge n+L, where L is 1 for flow-through and 2 for pipelined. Values on those pins at any other edge have no effect.
- R3: For a read sampled at edge n, the word is on `rdata`/`rpar` with `oe` high during the clock period that ends at edge n+L, with L as in R2.
- R4: In every period that does not carry read data, `oe` is low and `rdata` and `rpar` are all zeros.
- R5: `bw[i]` high writes data byte i (bits 8i+7..8i) and parity bit i. Lanes with a low enable keep their old contents, and a write with no enables changes nothing.
- R6: A read returns the result of all earlier writes in issue order. This includes a write issued on the immediately preceding edge, a write one edge older, and partial writes merged byte by byte.
- R7: Parity bit i travels with data byte i through storage and bypass, and is returned unchanged.
- R8: Eight accesses alternating write and read, issued on consecutive edges, finish with the last transfer sampled at clock 10 (pipelined) or clock 9 (flow-through), counting the first address edge as clock 1.
- R9: Reset (`rst_n` low) forces `oe` low and the outputs to zero. It also drops any write whose data capture or commit edge falls inside reset. Array contents are otherwise kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| ce | input | 1 | Chip enable for the access at this edge |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| bw | input | BYTES | Per-byte write enables, sampled with the address |
| wdata | input | BYTES*BYTE_W | Write data bus, taken L edges after the address |
| wpar | input | BYTES | Write parity, one bit per byte |
| rdata | output | BYTES*BYTE_W | Read data, zero when not driven |
| rpar | output | BYTES | Read parity, zero when not driven |
| oe | output | 1 | Output-enable flag standing in for the bus driver |

## Verification
The bench builds two copies side by side from one address and control stream: one with `PIPELINED=1` and one with `PIPELINED=0`, both with 64 words of four 9-bit lanes. Each copy gets its own write data bus, timed to its own latency. Both copies must return the same values, each in its own slot. Running both latency variants together makes it possible to hit both bypass sources in one run, for the same back-to-back and one-gap read-after-write patterns: the pending register, and in the pipelined copy the word arriving on the bus. It also exercises the 9-versus-10 clock schedule of an alternating burst, and a reset that drops a write at different stages in each copy.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTES = 4,
  parameter int BYTE_W = 8,
  parameter bit PIPELINED = 1'b1,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  bw,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  wpar,
  output logic [DATA_W-1:0] rdata,
  output logic [BYTES-1:0]  rpar,
  output logic              oe
);
  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = BYTES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [WORD_W-1:0] pack(input logic [DATA_W-1:0] d, input logic [BYTES-1:0] p);
    for (int b = 0; b < BYTES; b++) pack[b*LANE_W +: LANE_W] = {p[b], d[b*BYTE_W +: BYTE_W]};
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] base,
                                              input logic [WORD_W-1:0] upd,
                                              input logic [BYTES-1:0]  en);
    merge = base;
    for (int b = 0; b < BYTES; b++)
      if (en[b]) merge[b*LANE_W +: LANE_W] = upd[b*LANE_W +: LANE_W];
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];

  // address/control stage 1
  logic              s1_v, s1_we;
  logic [ADDR_W-1:0] s1_addr;
  logic [BYTES-1:0]  s1_bw;

  always_ff @(posedge clk) begin
    s1_v    <= rst_n ? ce : 1'b0;
    s1_we   <= we;
    s1_addr <= addr;
    s1_bw   <= bw;
  end

  // stage whose write data is on the bus now
  logic              cap_w;
  logic [ADDR_W-1:0] cap_addr;
  logic [BYTES-1:0]  cap_bw;

  generate
    if (PIPELINED) begin : g_cap_pipe
      logic              s2_v, s2_we;
      logic [ADDR_W-1:0] s2_addr;
      logic [BYTES-1:0]  s2_bw;
      always_ff @(posedge clk) begin
        s2_v    <= rst_n ? s1_v : 1'b0;
        s2_we   <= s1_we;
        s2_addr <= s1_addr;
        s2_bw   <= s1_bw;
      end
      assign cap_w    = s2_v & s2_we;
      assign cap_addr = s2_addr;
      assign cap_bw   = s2_bw;
    end else begin : g_cap_flow
      assign cap_w    = s1_v & s1_we;
      assign cap_addr = s1_addr;
      assign cap_bw   = s1_bw;
    end
  endgenerate

  wire [WORD_W-1:0] in_word = pack(wdata, wpar);

  // captured write waiting for its array commit
  logic              p_v;
  logic [ADDR_W-1:0] p_addr;
  logic [BYTES-1:0]  p_bw;
  logic [WORD_W-1:0] p_word;

  always_ff @(posedge clk) begin
    p_v    <= rst_n ? cap_w : 1'b0;
    p_addr <= cap_addr;
    p_bw   <= cap_bw;
    p_word <= in_word;
  end

  always_ff @(posedge clk)
    if (rst_n && p_v) mem[p_addr] <= merge(mem[p_addr], p_word, p_bw);

  // read path with two-level bypass: pending word, then word on the bus
  wire              rd_now  = s1_v & ~s1_we;
  wire              hit_p   = p_v & (p_addr == s1_addr);
  wire              hit_bus = cap_w & (cap_addr == s1_addr);
  wire [WORD_W-1:0] rv_p    = merge(mem[s1_addr], p_word, hit_p ? p_bw : '0);
  wire [WORD_W-1:0] rv      = merge(rv_p, in_word, hit_bus ? cap_bw : '0);

  logic [WORD_W-1:0] out_word;

  generate
    if (PIPELINED) begin : g_out_pipe
      logic              q_oe;
      logic [WORD_W-1:0] q_word;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_oe   <= 1'b0;
          q_word <= '0;
        end else begin
          q_oe   <= rd_now;
          q_word <= rd_now ? rv : '0;
        end
      end
      assign oe       = q_oe;
      assign out_word = q_word;
    end else begin : g_out_flow
      assign oe       = rd_now;
      assign out_word = rd_now ? rv : '0;
    end
  endgenerate

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign rdata[b*BYTE_W +: BYTE_W] = out_word[b*LANE_W +: BYTE_W];
      assign rpar[b]                   = out_word[b*LANE_W + BYTE_W];
    end
  endgenerate
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int BYTES = 4,
  parameter int BYTE_W = 8,
  parameter bit PIPELINED = 1'b1,
  localparam int DATA_W = BYTES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTES-1:0]  bw,
  input logic [DATA_W-1:0] wdata,
  input logic [BYTES-1:0]  wpar,
  input logic [DATA_W-1:0] rdata,
  input logic [BYTES-1:0]  rpar,
  input logic              oe
);
  localparam int LAT = PIPELINED ? 2 : 1;

  logic [1:0] since_rst;
  always_ff @(posedge clk)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (rdata == '0) && (rpar == '0));

  // also covers R1: a disabled edge never opens a data slot
  p_oe_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'(LAT)) |-> (oe == $past(ce && !we, LAT)));

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !oe);

  p_fwd_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 2'(LAT + 1)) && $past(ce && we && (&bw), LAT + 1) && $past(ce && !we, LAT)
     && ($past(addr, LAT + 1) == $past(addr, LAT)))
    |-> oe && (rdata == $past(wdata, 1)) && (rpar == $past(wpar, 1)));
endmodule

bind zbt_sram zbt_sram_chk #(
  .ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W), .PIPELINED(PIPELINED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .bw(bw),
  .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar), .oe(oe)
);

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int NT = 22;
  localparam logic [DW-1:0] JUNK_D = 32'hDEADBEEF;  // R2: must never land

  // {tag, ce, we, addr, bw, data, par}
  localparam logic [51:0] TBL [NT] = '{
    {4'd2, 1'b1, 1'b1, 6'd3,  4'hF, 32'h11223344, 4'h5},
    {4'd2, 1'b1, 1'b1, 6'd7,  4'hF, 32'hA5A5A5A5, 4'hF},
    {4'd6, 1'b1, 1'b0, 6'd3,  4'h0, 32'h0,        4'h0},  // R6 one-gap hit
    {4'd5, 1'b1, 1'b1, 6'd3,  4'h5, 32'hFFEEDDCC, 4'h0},  // R5 partial
    {4'd6, 1'b1, 1'b0, 6'd3,  4'h0, 32'h0,        4'h0},  // R6 back-to-back merge
    {4'd1, 1'b0, 1'b1, 6'd3,  4'hF, 32'h0,        4'h0},  // R1 disabled write
    {4'd1, 1'b1, 1'b0, 6'd3,  4'h0, 32'h0,        4'h0},
    {4'd7, 1'b1, 1'b1, 6'd9,  4'hF, 32'h01020304, 4'hA},
    {4'd7, 1'b1, 1'b1, 6'd9,  4'h8, 32'h77000000, 4'h8},
    {4'd7, 1'b1, 1'b0, 6'd9,  4'h0, 32'h0,        4'h0},  // R7 parity merge
    {4'd6, 1'b1, 1'b0, 6'd7,  4'h0, 32'h0,        4'h0},
    {4'd5, 1'b1, 1'b1, 6'd7,  4'h0, 32'hFFFFFFFF, 4'hF},  // R5 no enables
    {4'd5, 1'b1, 1'b0, 6'd7,  4'h0, 32'h0,        4'h0},
    {4'd6, 1'b1, 1'b1, 6'd12, 4'hF, 32'hCAFEF00D, 4'h3},
    {4'd6, 1'b1, 1'b0, 6'd12, 4'h0, 32'h0,        4'h0},
    {4'd5, 1'b1, 1'b1, 6'd12, 4'h2, 32'h0000BE00, 4'h2},
    {4'd1, 1'b0, 1'b0, 6'd12, 4'h0, 32'h0,        4'h0},
    {4'd6, 1'b1, 1'b0, 6'd12, 4'h0, 32'h0,        4'h0},
    {4'd6, 1'b1, 1'b0, 6'd9,  4'h0, 32'h0,        4'h0},
    {4'd6, 1'b1, 1'b0, 6'd3,  4'h0, 32'h0,        4'h0},
    {4'd2, 1'b1, 1'b1, 6'd5,  4'hF, 32'h5555AAAA, 4'h6},
    {4'd3, 1'b1, 1'b0, 6'd5,  4'h0, 32'h0,        4'h0}   // R3 slot timing
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ce, we;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw;
  logic [DW-1:0] wd_pl, wd_ft, rd_pl, rd_ft;
  logic [NB-1:0] wp_pl, wp_ft, rp_pl, rp_ft;
  logic          oe_pl, oe_ft;

  zbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8), .PIPELINED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .bw(bw),
    .wdata(wd_pl), .wpar(wp_pl), .rdata(rd_pl), .rpar(rp_pl), .oe(oe_pl));

  zbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8), .PIPELINED(1'b0)) u_dut_ft (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .bw(bw),
    .wdata(wd_ft), .wpar(wp_ft), .rdata(rd_ft), .rpar(rp_ft), .oe(oe_ft));

  int checks = 0, fails = 0, n_ops = 0, last_pl = 0, last_ft = 0;
  string         o_tag [64];
  logic          o_ce [64], o_we [64];
  logic [AW-1:0] o_addr [64];
  logic [NB-1:0] o_bw [64], o_p [64], e_p [64];
  logic [DW-1:0] o_d [64], e_d [64];
  logic [DW-1:0] m_d [64];
  logic [NB-1:0] m_p [64];

  task automatic check(string tag, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add_op(string tag, logic c, logic w, logic [AW-1:0] a, logic [NB-1:0] b,
                        logic [DW-1:0] d, logic [NB-1:0] p);
    o_tag[n_ops] = tag; o_ce[n_ops] = c; o_we[n_ops] = w; o_addr[n_ops] = a;
    o_bw[n_ops] = b; o_d[n_ops] = d; o_p[n_ops] = p;
    e_d[n_ops] = '0; e_p[n_ops] = '0;
    if (c && !w) begin
      e_d[n_ops] = m_d[a]; e_p[n_ops] = m_p[a];
    end
    if (c && w)
      for (int j = 0; j < NB; j++)
        if (b[j]) begin
          m_d[a][j*8 +: 8] = d[j*8 +: 8];
          m_p[a][j] = p[j];
        end
    n_ops++;
  endtask

  task automatic slot_check(string mode, int k, logic [39:0] obs);
    logic [39:0] exp;
    string tag;
    exp = '0;
    tag = "R4";
    if (k < n_ops) begin
      if (o_ce[k] && !o_we[k]) exp = {3'b0, 1'b1, e_p[k], e_d[k]};
      if (o_ce[k] && !o_we[k]) tag = o_tag[k];
    end
    check(tag, $sformatf("%s slot of op %0d", mode, k), obs, exp);
  endtask

  task automatic run_ops();
    last_pl = 0; last_ft = 0;
    for (int i = 0; i < n_ops + 3; i++) begin
      @(negedge clk);
      if (i >= 1) slot_check("flow", i - 1, {3'b0, oe_ft, rp_ft, rd_ft});
      if (i >= 2) slot_check("pipe", i - 2, {3'b0, oe_pl, rp_pl, rd_pl});
      if (oe_ft) last_ft = i + 1;
      if (oe_pl) last_pl = i + 1;
      if (i < n_ops) begin
        ce = o_ce[i]; we = o_we[i]; addr = o_addr[i]; bw = o_bw[i];
      end else begin
        ce = 1'b0; we = 1'b0;
      end
      wd_ft = JUNK_D; wp_ft = 4'hF; wd_pl = ~JUNK_D; wp_pl = 4'hF;
      if (i >= 1 && i - 1 < n_ops && o_ce[i-1] && o_we[i-1]) begin
        wd_ft = o_d[i-1]; wp_ft = o_p[i-1];
      end
      if (i >= 2 && i - 2 < n_ops && o_ce[i-2] && o_we[i-2]) begin
        wd_pl = o_d[i-2]; wp_pl = o_p[i-2];
      end
    end
    n_ops = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ce = 1'b0; we = 1'b0; addr = '0; bw = '0;
    wd_pl = JUNK_D; wd_ft = JUNK_D; wp_pl = '0; wp_ft = '0;
    repeat (3) @(negedge clk);
    check("R9", "pipe outputs in reset", {3'b0, oe_pl, rp_pl, rd_pl}, '0);
    check("R9", "flow outputs in reset", {3'b0, oe_ft, rp_ft, rd_ft}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NT; i++)
      add_op($sformatf("R%0d", TBL[i][51:48]), TBL[i][47], TBL[i][46], TBL[i][45:40],
             TBL[i][39:36], TBL[i][35:4], TBL[i][3:0]);
    run_ops();

    // R8 alternating burst with bus busy every slot
    add_op("R8", 1, 1, 20, 4'hF, 32'h20202020, 4'h1);
    add_op("R8", 1, 0, 3,  4'h0, 32'h0, 4'h0);
    add_op("R8", 1, 1, 21, 4'hF, 32'h21212121, 4'h2);
    add_op("R8", 1, 0, 20, 4'h0, 32'h0, 4'h0);
    add_op("R8", 1, 1, 22, 4'hF, 32'h22222222, 4'h4);
    add_op("R8", 1, 0, 21, 4'h0, 32'h0, 4'h0);
    add_op("R8", 1, 1, 23, 4'hF, 32'h23232323, 4'h8);
    add_op("R8", 1, 0, 22, 4'h0, 32'h0, 4'h0);
    run_ops();
    check("R8", "pipe clocks for eight accesses", 40'(last_pl), 40'd10);
    check("R8", "flow clocks for eight accesses", 40'(last_ft), 40'd9);

    // R9 write interrupted by reset is dropped
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = 6'd5; bw = 4'hF;
    wd_pl = '0; wd_ft = '0; wp_pl = '0; wp_ft = '0;
    @(negedge clk);
    ce = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "pipe oe in reset", {39'b0, oe_pl}, '0);
    check("R9", "flow oe in reset", {39'b0, oe_ft}, '0);
    rst_n = 1'b1;
    add_op("R9", 1, 0, 5, 4'h0, 32'h0, 4'h0);
    run_ops();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule